// File: doc/BRIEF.md
# ULPI Link-Side Bus Controller

This block sits on the link side of the 12-signal ULPI bus that connects a USB link to its transceiver. The 8-bit data bus is shared in both directions, and the transceiver decides who owns it through a direction input. While direction is low, the block drives bytes from a local transmit stream onto the bus. It advances to the next byte only when the transceiver strobes `ulpi_nxt`. It closes each packet with a one-cycle stop strobe.

While direction is high, the block releases the bus and forwards the bytes it receives to a local receive stream. Each received byte is marked as either packet data or a status byte.

A one-cycle turnaround follows every change of direction, and no byte moves in that cycle. If the transceiver takes the bus in the middle of a packet, the packet is abandoned and the abandonment is reported to the local source. If the transceiver's data runs dry in the middle of a packet, or the transceiver reports sleep, the packet is abandoned in the same way. Everything runs on one 60 MHz clock, with a synchronous active-high reset.

Top module: `ulpi_link`

## Requirements
- R1: While and after reset, `ulpi_data_oe`, `ulpi_stp`, `rx_valid`, `rx_end` and `tx_abort` are 0, and no transmit byte is pending.
- R2: `ulpi_data_oe` is 0 in every cycle in which `ulpi_dir` is 1, including the first such cycle, because the gating is combinational.
- R3: In idle, when the bus is link-owned and not in turnaround, `tx_ready` is 1 in the same cycle. When `tx_valid` is also 1, the byte is taken, and from the next cycle it is driven with `ulpi_data_oe` = 1.
- R4: A driven byte stays on the bus until `ulpi_nxt` is 1. In that cycle, if the byte is not the last one, `tx_ready` is 1 and the next source byte appears on the bus in the following cycle.
- R5: When the byte marked `tx_last` is accepted with `ulpi_nxt` = 1, the next cycle has `ulpi_stp` = 1 for exactly one cycle, with data 0x00 and `ulpi_data_oe` = 1. The cycle after that is idle, with `ulpi_data_oe` = 0.
- R6: If `ulpi_dir` rises while a packet is being sent, `tx_abort` pulses for one cycle in the next cycle, and `ulpi_stp` stays 0.
- R7: If `ulpi_nxt` accepts a byte that is not the last one while `tx_valid` is 0, the packet is abandoned and `tx_abort` pulses in the next cycle.
- R8: In the first cycle after `ulpi_dir` changes, no receive byte is captured, and `tx_ready` is 0.
- R9: A byte seen while `ulpi_dir` is 1 and the bus is not in turnaround appears on `rx_data` in the next cycle with `rx_valid` = 1. `rx_status` is 1 when `ulpi_nxt` was 0 (status byte) and 0 when `ulpi_nxt` was 1 (packet data).
- R10: `rx_end` pulses for one cycle in the cycle after the one in which `ulpi_dir` falls.
- R11: While `ulpi_sleep` is 1, the bus counts as undriven. `ulpi_data_oe` and `tx_ready` are 0, no byte is captured, and a packet in progress is abandoned with a `tx_abort` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 60 MHz interface clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_valid | input | 1 | Local source offers a byte |
| tx_data | input | 8 | Byte offered for transmit |
| tx_last | input | 1 | Offered byte ends the packet |
| tx_ready | output | 1 | Offered byte is taken this cycle |
| tx_abort | output | 1 | One-cycle pulse: packet abandoned |
| rx_valid | output | 1 | Received byte valid |
| rx_data | output | 8 | Received byte |
| rx_status | output | 1 | Received byte is a status byte |
| rx_end | output | 1 | One-cycle pulse: transceiver released the bus |
| ulpi_dir | input | 1 | Transceiver owns the bus when 1 |
| ulpi_nxt | input | 1 | Transceiver accept / data strobe |
| ulpi_stp | output | 1 | Stop strobe ending a transmit packet |
| ulpi_sleep | input | 1 | Transceiver is asleep; its outputs are floating |
| ulpi_data_in | input | 8 | Data bus as seen by the link |
| ulpi_data_out | output | 8 | Data the link drives |
| ulpi_data_oe | output | 1 | Link output enable for the data bus |

## Verification
The hardest situations to reach are the ones where the transceiver's control inputs cut across a packet in progress. Examples are direction rising while a byte waits for acceptance, an accept strobe arriving when the local source has nothing more, and sleep asserting in the middle of a packet. The directed tests start a packet and then flip `ulpi_dir`, withhold `tx_valid` or raise `ulpi_sleep` exactly one cycle later. They then check, in the same cycle, that the output enable is off, and in the next cycle that the abort pulse appears and no stop strobe does. A table-driven receive sequence covers the turnaround cycles on both edges of direction, and the data/status split.

// File: rtl/ulpi_link_pkg.sv
package ulpi_link_pkg;

  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_SEND = 2'd1,
    TX_STOP = 2'd2
  } tx_state_e;

  // Link may start driving: bus is ours, settled, and the transceiver is awake.
  function automatic logic bus_free(input logic dir, input logic turn, input logic sleep);
    return !dir && !turn && !sleep;
  endfunction

  // A received byte is a status byte when the accept strobe is low.
  function automatic logic rx_is_status(input logic nxt);
    return !nxt;
  endfunction

endpackage

// File: rtl/ulpi_turnaround.sv
module ulpi_turnaround (
  input  logic clk,
  input  logic rst,
  input  logic dir_i,
  output logic turn_o,
  output logic dir_fall_o
);
  logic dir_q;

  always_ff @(posedge clk) begin
    if (rst) dir_q <= 1'b0;
    else     dir_q <= dir_i;
  end

  assign turn_o     = dir_i ^ dir_q;
  assign dir_fall_o = dir_q && !dir_i;
endmodule

// File: rtl/ulpi_tx_ctrl.sv
module ulpi_tx_ctrl
  import ulpi_link_pkg::*;
#(
  parameter int W         = 8,
  parameter logic [W-1:0] STOP_BYTE = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         dir_i,
  input  logic         turn_i,
  input  logic         sleep_i,
  input  logic         nxt_i,
  input  logic         tx_valid_i,
  input  logic [W-1:0] tx_data_i,
  input  logic         tx_last_i,
  output logic         tx_ready_o,
  output logic         tx_abort_o,
  output logic         stp_o,
  output logic [W-1:0] data_o,
  output logic         oe_o
);
  tx_state_e    state;
  logic [W-1:0] hold;
  logic         hold_last;

  // Named internal events
  logic free_w, start_w, beat_w, lost_w, underrun_w;

  always_comb begin
    free_w     = bus_free(dir_i, turn_i, sleep_i);
    start_w    = (state == TX_IDLE) && free_w && tx_valid_i;
    beat_w     = (state == TX_SEND) && nxt_i && !dir_i && !sleep_i;
    lost_w     = (state == TX_SEND) && (dir_i || sleep_i);
    underrun_w = beat_w && !hold_last && !tx_valid_i;
    tx_ready_o = ((state == TX_IDLE) && free_w) || (beat_w && !hold_last);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= TX_IDLE;
      hold       <= '0;
      hold_last  <= 1'b0;
      tx_abort_o <= 1'b0;
    end else begin
      tx_abort_o <= lost_w || underrun_w;
      unique case (state)
        TX_IDLE: if (start_w) begin
          hold      <= tx_data_i;
          hold_last <= tx_last_i;
          state     <= TX_SEND;
        end
        TX_SEND: begin
          if (lost_w || underrun_w) begin
            state     <= TX_IDLE;
            hold_last <= 1'b0;
          end else if (beat_w) begin
            if (hold_last) begin
              state <= TX_STOP;
            end else begin
              hold      <= tx_data_i;
              hold_last <= tx_last_i;
            end
          end
        end
        TX_STOP: state <= TX_IDLE;
        default: state <= TX_IDLE;
      endcase
    end
  end

  assign stp_o  = (state == TX_STOP);
  assign data_o = (state == TX_STOP) ? STOP_BYTE : hold;
  assign oe_o   = (state != TX_IDLE) && !dir_i && !sleep_i;

  p_stp_single_r5: assert property (@(posedge clk) disable iff (rst)
    stp_o |=> !stp_o);
  p_stp_after_accept_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(stp_o) |-> $past(nxt_i));
  p_abort_no_stp_r6: assert property (@(posedge clk) disable iff (rst)
    tx_abort_o |-> !stp_o);
endmodule

// File: rtl/ulpi_rx_capture.sv
module ulpi_rx_capture
  import ulpi_link_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         dir_i,
  input  logic         turn_i,
  input  logic         dir_fall_i,
  input  logic         nxt_i,
  input  logic [W-1:0] data_i,
  output logic         rx_valid_o,
  output logic [W-1:0] rx_data_o,
  output logic         rx_status_o,
  output logic         rx_end_o
);
  logic take_w;
  assign take_w = dir_i && !turn_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_valid_o  <= 1'b0;
      rx_data_o   <= '0;
      rx_status_o <= 1'b0;
      rx_end_o    <= 1'b0;
    end else begin
      rx_valid_o  <= take_w;
      rx_status_o <= take_w && rx_is_status(nxt_i);
      rx_end_o    <= dir_fall_i;
      if (take_w) rx_data_o <= data_i;
    end
  end

  p_rx_no_turn_r8: assert property (@(posedge clk) disable iff (rst)
    rx_valid_o |-> $past(dir_i) && !$past(turn_i));
  p_end_after_fall_r10: assert property (@(posedge clk) disable iff (rst)
    rx_end_o |-> !$past(dir_i));
endmodule

// File: rtl/ulpi_link.sv
module ulpi_link
  import ulpi_link_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tx_valid,
  input  logic [W-1:0] tx_data,
  input  logic         tx_last,
  output logic         tx_ready,
  output logic         tx_abort,
  output logic         rx_valid,
  output logic [W-1:0] rx_data,
  output logic         rx_status,
  output logic         rx_end,
  input  logic         ulpi_dir,
  input  logic         ulpi_nxt,
  output logic         ulpi_stp,
  input  logic         ulpi_sleep,
  input  logic [W-1:0] ulpi_data_in,
  output logic [W-1:0] ulpi_data_out,
  output logic         ulpi_data_oe
);
  // Direction as seen by the link: a sleeping transceiver drives nothing.
  logic dir_eff, turn_w, dir_fall_w;
  assign dir_eff = ulpi_dir && !ulpi_sleep;

  ulpi_turnaround u_turn (
    .clk(clk), .rst(rst), .dir_i(dir_eff),
    .turn_o(turn_w), .dir_fall_o(dir_fall_w)
  );

  ulpi_tx_ctrl #(.W(W), .STOP_BYTE('0)) u_tx (
    .clk(clk), .rst(rst), .dir_i(ulpi_dir), .turn_i(turn_w),
    .sleep_i(ulpi_sleep), .nxt_i(ulpi_nxt),
    .tx_valid_i(tx_valid), .tx_data_i(tx_data), .tx_last_i(tx_last),
    .tx_ready_o(tx_ready), .tx_abort_o(tx_abort),
    .stp_o(ulpi_stp), .data_o(ulpi_data_out), .oe_o(ulpi_data_oe)
  );

  ulpi_rx_capture #(.W(W)) u_rx (
    .clk(clk), .rst(rst), .dir_i(dir_eff), .turn_i(turn_w),
    .dir_fall_i(dir_fall_w), .nxt_i(ulpi_nxt), .data_i(ulpi_data_in),
    .rx_valid_o(rx_valid), .rx_data_o(rx_data),
    .rx_status_o(rx_status), .rx_end_o(rx_end)
  );

  p_oe_off_dir_r2: assert property (@(posedge clk) disable iff (rst)
    ulpi_dir |-> !ulpi_data_oe);
  p_sleep_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    ulpi_sleep |-> !ulpi_data_oe && !tx_ready);
  p_abort_single_r6: assert property (@(posedge clk) disable iff (rst)
    tx_abort |=> !tx_abort);
endmodule

// File: tb/tb_ulpi_link.sv
module tb_ulpi_link;
  logic clk = 1'b0;
  logic rst;
  logic tx_valid, tx_last, tx_ready, tx_abort;
  logic [7:0] tx_data, rx_data, ulpi_data_in, ulpi_data_out;
  logic rx_valid, rx_status, rx_end;
  logic ulpi_dir, ulpi_nxt, ulpi_stp, ulpi_sleep, ulpi_data_oe;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ulpi_link dut (
    .clk(clk), .rst(rst), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_last(tx_last), .tx_ready(tx_ready), .tx_abort(tx_abort),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_status(rx_status),
    .rx_end(rx_end), .ulpi_dir(ulpi_dir), .ulpi_nxt(ulpi_nxt),
    .ulpi_stp(ulpi_stp), .ulpi_sleep(ulpi_sleep),
    .ulpi_data_in(ulpi_data_in), .ulpi_data_out(ulpi_data_out),
    .ulpi_data_oe(ulpi_data_oe)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Inputs change on the falling edge; checks follow 1 ns later.
  task automatic step();
    @(negedge clk);
  endtask

  // Receive vectors: {dir, nxt, din[7:0], exp_valid, exp_status, exp_data[7:0], exp_end}
  // Expected outputs are those visible in the same cycle (registered from the previous row).
  localparam int NV = 8;
  localparam logic [20:0] VEC [NV] = '{
    {1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0},
    {1'b1, 1'b0, 8'hAA, 1'b0, 1'b0, 8'h00, 1'b0},  // rising turnaround
    {1'b1, 1'b0, 8'h46, 1'b0, 1'b0, 8'h00, 1'b0},
    {1'b1, 1'b1, 8'hC3, 1'b1, 1'b1, 8'h46, 1'b0},  // status seen
    {1'b1, 1'b1, 8'h5A, 1'b1, 1'b0, 8'hC3, 1'b0},  // data seen
    {1'b0, 1'b0, 8'hFF, 1'b1, 1'b0, 8'h5A, 1'b0},  // falling turnaround
    {1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1},  // end pulse
    {1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0}
  };

  initial begin
    #150000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; tx_valid = 0; tx_data = 0; tx_last = 0;
    ulpi_dir = 0; ulpi_nxt = 0; ulpi_sleep = 0; ulpi_data_in = 0;
    step(); step(); #1;
    // R1 reset state
    chk("R1 oe", ulpi_data_oe, 0); chk("R1 stp", ulpi_stp, 0);
    chk("R1 rx_valid", rx_valid, 0); chk("R1 abort", tx_abort, 0);
    chk("R1 rx_end", rx_end, 0);
    rst = 1'b0;

    // R9/R8/R10 receive table
    for (int i = 0; i < NV; i++) begin
      step();
      ulpi_dir = VEC[i][20]; ulpi_nxt = VEC[i][19]; ulpi_data_in = VEC[i][18:11];
      #1;
      chk("R8/R9 rx_valid", rx_valid, VEC[i][10]);
      if (VEC[i][10]) begin
        chk("R9 rx_status", rx_status, VEC[i][9]);
        chk("R9 rx_data", rx_data, VEC[i][8:1]);
      end
      chk("R10 rx_end", rx_end, VEC[i][0]);
      if (i == 1 || i == 5) chk("R2/R8 tx_ready in turnaround", tx_ready, 0);
    end
    ulpi_nxt = 0;

    // R3/R4/R5 normal packet: 41, 11, 22(last)
    step(); tx_valid = 1; tx_data = 8'h41; tx_last = 0; #1;
    chk("R3 ready idle", tx_ready, 1);
    step(); tx_data = 8'h11; ulpi_nxt = 0; #1;
    chk("R3 oe", ulpi_data_oe, 1); chk("R3 data", ulpi_data_out, 8'h41);
    chk("R4 held no ready", tx_ready, 0);
    step(); ulpi_nxt = 1; #1;
    chk("R4 still held", ulpi_data_out, 8'h41); chk("R4 ready on nxt", tx_ready, 1);
    step(); tx_data = 8'h22; tx_last = 1; #1;
    chk("R4 next byte", ulpi_data_out, 8'h11);
    step(); tx_valid = 0; tx_last = 0; #1;
    chk("R4 last byte", ulpi_data_out, 8'h22); chk("R5 no ready on last", tx_ready, 0);
    step(); ulpi_nxt = 0; #1;
    chk("R5 stp", ulpi_stp, 1); chk("R5 stop data", ulpi_data_out, 8'h00);
    chk("R5 stop oe", ulpi_data_oe, 1);
    step(); #1;
    chk("R5 stp once", ulpi_stp, 0); chk("R5 idle oe", ulpi_data_oe, 0);

    // R6 abort on direction rise
    step(); tx_valid = 1; tx_data = 8'h43; tx_last = 0; #1;
    step(); tx_valid = 0; ulpi_dir = 1; #1;
    chk("R2 oe off same cycle", ulpi_data_oe, 0);
    step(); #1;
    chk("R6 abort", tx_abort, 1); chk("R6 no stp", ulpi_stp, 0);
    step(); #1;
    chk("R6 abort single", tx_abort, 0);
    // R8 falling turnaround blocks start
    step(); ulpi_dir = 0; tx_valid = 1; tx_data = 8'h44; #1;
    chk("R8 no ready turnaround", tx_ready, 0);
    step(); #1;
    chk("R3 ready after turnaround", tx_ready, 1);
    // R7 underrun
    step(); tx_valid = 0; ulpi_nxt = 1; #1;
    chk("R3 driving", ulpi_data_out, 8'h44);
    step(); ulpi_nxt = 0; #1;
    chk("R7 abort underrun", tx_abort, 1); chk("R7 oe off", ulpi_data_oe, 0);
    chk("R7 no stp", ulpi_stp, 0);

    // R11 sleep
    step(); tx_valid = 1; tx_data = 8'h45; #1;
    step(); tx_valid = 0; ulpi_sleep = 1; #1;
    chk("R11 oe off", ulpi_data_oe, 0);
    step(); ulpi_dir = 1; ulpi_data_in = 8'h77; tx_valid = 1; #1;
    chk("R11 abort", tx_abort, 1); chk("R11 no ready", tx_ready, 0);
    step(); #1;
    chk("R11 no capture", rx_valid, 0);
    step(); #1;
    chk("R11 no capture later", rx_valid, 0);
    ulpi_dir = 0; ulpi_sleep = 0; tx_valid = 0;

    // R1 reset empties a pending byte
    step(); tx_valid = 1; tx_data = 8'h55; #1;
    step(); rst = 1; tx_valid = 0; #1;
    step(); rst = 0; #1;
    chk("R1 reset clears oe", ulpi_data_oe, 0);
    chk("R1 reset clears stp", ulpi_stp, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule